// File: doc/BRIEF.md
# Fractional Clock Divider Generator

This block derives one divided clock from a fast reference clock. The divisor is a fixed-point number with an integer part and an 8-bit fraction. The design is a clock-enable style generator: everything runs in the reference domain. The output is a 2-bit half-cycle pair for each reference cycle. A downstream double-data-rate output stage turns that pair into a real waveform. With this encoding, divide-by-one and exact 50% duty on odd divisors can both be expressed without a second clock.

Software writes two words through a small write port. The control word holds:
- run enable,
- an immediate stop,
- duty-cycle correction,
- a 0..3 cycle enable delay,
- a phase-nudge bit.

The divisor word can be rewritten while the generator runs. A new value is applied only at the next period boundary. Starting and stopping are clean: a period never begins part-way through, and a period that has begun always runs to its end. The immediate stop is the one exception, and it is allowed to cut a period short.

Top module: `frac_clkgen`

## Requirements
- R1: After reset the output pair is 00, the control word is all zero and the divisor is 1.0 (integer 1, fraction 0).
- R2: Each period lasts I + c reference cycles. I is the integer field. c is the carry out of an 8-bit accumulator to which the fraction is added once per period. The accumulator is zero after reset and after a stop.
- R3: Output pair encoding: bit 1 is the first half of a reference cycle and bit 0 is the second half. A period of L cycles is high first and then low. For L > 1 that is odd and correction is off, the high time is L-1 half-cycles. In every other case the high time is L half-cycles.
- R4: With a period of one cycle, the output is 10 in every cycle.
- R5: An integer field of zero gives a period of 65536 cycles.
- R6: A divisor written while running leaves the current period unchanged. The new value applies from the next period.
- R7: Enabling starts at a period boundary. When the block is idle, a control write in cycle t that sets enable (bit 0) with delay field D (bits 4:3) first gives a nonzero output in cycle t+2+D.
- R8: Clearing enable lets the period in progress finish before the output stays at 00.
- R9: Stop (bit 1) forces the output to 00 from the cycle after the write, whatever enable says. It also clears the period state and the accumulator.
- R10: Each change of the nudge bit (bit 5) inserts one idle 00 cycle at the next period boundary. This delays the phase by one cycle.
- R11: While disabled and idle, the output is held at 00.

Register map: address 0 is control (bit 0 enable, bit 1 stop, bit 2 duty correction, bits 4:3 delay, bit 5 nudge). Address 1 is the divisor (bits 31:8 integer, bits 7:0 fraction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects control, 1 selects divisor |
| cfg_wdata | input | 32 | Write data |
| clk_pair | output | 2 | Half-cycle output levels: bit 1 first half, bit 0 second half |

## Verification
The assertions assume a few things about the inputs:
- the write port changes only between edges;
- the stop bit is the only input that may cut a period short;
- no divisor write happens while reset is high.

Under these assumptions, a running period must keep its length, must finish once disabling has begun, and must start on a high half-cycle. The stimulus follows the same rules. It always stops the generator before rewriting the control fields it measures. It changes the divisor or toggles the nudge bit right after a period starts, and only with periods of at least four cycles, so that each change falls inside a known period.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int FCG_DLY_W = 2;
  localparam int CTRL_W    = 6;

  // Control word: en is bit 0, nudge is bit 5.
  typedef struct packed {
    logic                 nudge;
    logic [FCG_DLY_W-1:0] delay;
    logic                 dc;
    logic                 kill;
    logic                 en;
  } fcg_ctrl_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DIV  = 1'b1;
endpackage

// File: rtl/fcg_regs.sv
module fcg_regs
  import fcg_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    addr,
  input  logic [INT_W+FRAC_W-1:0] wdata,
  output fcg_ctrl_t               ctrl,
  output logic [INT_W-1:0]        div_int,
  output logic [FRAC_W-1:0]       div_frac
);
  localparam int W = INT_W + FRAC_W;

  logic wdata_unused;
  assign wdata_unused = ^wdata[W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      div_int  <= INT_W'(1);
      div_frac <= '0;
    end else if (we) begin
      if (addr == ADDR_CTRL) ctrl <= fcg_ctrl_t'(wdata[CTRL_W-1:0]);
      else                   {div_int, div_frac} <= wdata;
    end
  end
endmodule

// File: rtl/fcg_gate.sv
module fcg_gate #(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             kill,
  input  logic [DLY_W-1:0] delay,
  input  logic             nudge,
  output logic             en_eff,
  output logic             nudge_evt
);
  localparam int NST = (1 << DLY_W) - 1;

  logic [NST-1:0] dly_q;
  logic [NST:0]   chain;
  logic           nudge_prev;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      dly_q <= '0;
    end else begin
      for (int i = NST - 1; i > 0; i--) dly_q[i] <= dly_q[i-1];
      dly_q[0] <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) nudge_prev <= 1'b0;
    else     nudge_prev <= nudge;
  end

  assign chain     = {dly_q, en};
  assign en_eff    = chain[delay];
  assign nudge_evt = nudge ^ nudge_prev;

  // R7: with a one-cycle delay the effective enable follows the enable one cycle later
  a_r7_one_cycle_delay: assert property (@(posedge clk) disable iff (rst)
    (delay == DLY_W'(1) && !$past(kill) && !$past(rst)) |-> (en_eff == $past(en)));
endmodule

// File: rtl/fcg_core.sv
module fcg_core #(
  parameter int INT_W    = 24,
  parameter int FRAC_W   = 8,
  parameter int ZERO_LOG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_eff,
  input  logic              kill,
  input  logic              nudge_evt,
  input  logic              dc,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic [1:0]        pair
);
  localparam int LEN_W = INT_W + 1;
  localparam int POS_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] ZERO_LEN = LEN_W'(1) << ZERO_LOG;

  logic              active_q, active_n;
  logic              pend_q, pend_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [LEN_W-1:0]  hs_q, hs_n;
  logic [FRAC_W-1:0] acc_q, acc_n;
  logic [1:0]        pair_q, pair_n;

  logic [LEN_W-1:0]  i_eff, new_len, new_hs;
  logic [FRAC_W:0]   sum;
  logic              at_end;

  function automatic logic [1:0] slot_pair(input logic [LEN_W-1:0] pos,
                                           input logic [LEN_W-1:0] hs);
    logic [POS_W-1:0] s0;
    s0 = {pos, 1'b0};
    return {(s0 < POS_W'(hs)), ((s0 + POS_W'(1)) < POS_W'(hs))};
  endfunction

  always_comb begin
    i_eff   = (div_int == '0) ? ZERO_LEN : LEN_W'(div_int);
    sum     = {1'b0, acc_q} + {1'b0, div_frac};
    new_len = i_eff + LEN_W'(sum[FRAC_W]);
    new_hs  = (new_len[0] && !dc && new_len != LEN_W'(1)) ? new_len - LEN_W'(1) : new_len;
    at_end  = !active_q || (cnt_q == len_q - LEN_W'(1));
  end

  always_comb begin
    active_n = active_q;
    pend_n   = pend_q;
    cnt_n    = cnt_q;
    len_n    = len_q;
    hs_n     = hs_q;
    acc_n    = acc_q;
    pair_n   = 2'b00;
    if (kill) begin
      active_n = 1'b0;
      pend_n   = 1'b0;
      cnt_n    = '0;
      acc_n    = '0;
    end else if (at_end) begin
      cnt_n = '0;
      if (en_eff && pend_q) begin
        active_n = 1'b0;
        pend_n   = nudge_evt;
      end else if (en_eff) begin
        active_n = 1'b1;
        pend_n   = nudge_evt;
        len_n    = new_len;
        hs_n     = new_hs;
        acc_n    = sum[FRAC_W-1:0];
        pair_n   = slot_pair('0, new_hs);
      end else begin
        active_n = 1'b0;
        pend_n   = pend_q | nudge_evt;
      end
    end else begin
      pend_n = pend_q | nudge_evt;
      cnt_n  = cnt_q + LEN_W'(1);
      pair_n = slot_pair(cnt_q + LEN_W'(1), hs_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      hs_q     <= '0;
      acc_q    <= '0;
      pair_q   <= 2'b00;
    end else begin
      active_q <= active_n;
      pend_q   <= pend_n;
      cnt_q    <= cnt_n;
      len_q    <= len_n;
      hs_q     <= hs_n;
      acc_q    <= acc_n;
      pair_q   <= pair_n;
    end
  end

  assign pair = pair_q;

  a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (len_q != '0 && cnt_q < len_q));
  a_r3_period_starts_high: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q == '0) |-> pair_q[1]);
  a_r6_len_held: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != '0) |-> $stable(len_q));
  a_r8_no_truncation: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != len_q - LEN_W'(1) && !kill) |=> active_q);
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!active_q && acc_q == '0 && pair_q == 2'b00));
  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> pair_q == 2'b00);
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
  import fcg_pkg::*;
#(
  parameter int INT_W    = 24,
  parameter int FRAC_W   = 8,
  parameter int ZERO_LOG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic                    cfg_addr,
  input  logic [INT_W+FRAC_W-1:0] cfg_wdata,
  output logic [1:0]              clk_pair
);
  fcg_ctrl_t         ctrl;
  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              en_eff, nudge_evt;
  logic [1:0]        core_pair;

  fcg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .div_int(div_int), .div_frac(div_frac)
  );

  fcg_gate #(.DLY_W(FCG_DLY_W)) u_gate (
    .clk(clk), .rst(rst), .en(ctrl.en), .kill(ctrl.kill), .delay(ctrl.delay),
    .nudge(ctrl.nudge), .en_eff(en_eff), .nudge_evt(nudge_evt)
  );

  fcg_core #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ZERO_LOG(ZERO_LOG)) u_core (
    .clk(clk), .rst(rst), .en_eff(en_eff), .kill(ctrl.kill), .nudge_evt(nudge_evt),
    .dc(ctrl.dc), .div_int(div_int), .div_frac(div_frac), .pair(core_pair)
  );

  // Stop overrides the registered pair at once.
  assign clk_pair = core_pair & {2{~ctrl.kill}};
endmodule

// File: tb/sim_frac_clkgen.sv
`timescale 1ns/1ps
module sim_frac_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  clk_pair;

  int nchk = 0;
  int nerr = 0;
  bit nud  = 1'b0;
  int acc_m = 0;
  int cut_seq = 0;

  int    exp_tot[$];
  int    exp_hi[$];
  string exp_tag[$];

  frac_clkgen u0 (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                  .cfg_wdata(cfg_wdata), .clk_pair(clk_pair));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int cw(input bit en, input bit kl, input bit dcv, input int dly);
    return int'(en) | (int'(kl) << 1) | (int'(dcv) << 2) | ((dly & 3) << 3) | (int'(nud) << 5);
  endfunction

  task automatic wr(input bit a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Expected period items from R2/R3: total half-slots and high half-slots.
  task automatic push_run(input int ival, input int fval, input bit dcv, input int n,
                          input string tag);
    for (int j = 0; j < n; j++) begin
      int s, len, hs;
      s   = acc_m + fval;
      len = ((ival == 0) ? 65536 : ival) + ((s >= 256) ? 1 : 0);
      acc_m = s % 256;
      hs  = ((len % 2) == 1 && !dcv && len != 1) ? len - 1 : len;
      exp_tot.push_back(2 * len); exp_hi.push_back(hs); exp_tag.push_back(tag);
    end
  endtask

  task automatic wait_empty(input string tag);
    int t = 0;
    while (exp_tot.size() != 0 && t < 140000) begin
      @(posedge clk); t++;
    end
    if (exp_tot.size() != 0) begin
      chk(1'b0, {tag, " scoreboard drained"}, exp_tot.size(), 0);
      exp_tot.delete(); exp_hi.delete(); exp_tag.delete();
    end
  endtask

  task automatic run_case(input int ival, input int fval, input bit dcv, input int n,
                          input string tag);
    wr(1'b0, cw(1'b0, 1'b1, 1'b0, 0));
    wr(1'b0, cw(1'b0, 1'b0, 1'b0, 0));
    wr(1'b1, (ival << 8) | fval);
    @(posedge clk);
    cut_seq++;
    acc_m = 0;
    push_run(ival, fval, dcv, n, tag);
    wr(1'b0, cw(1'b1, 1'b0, dcv, 0));
    wait_empty(tag);
  endtask

  // Monitor: rebuilds periods from the half-slot stream and scores them.
  bit started = 1'b0, prevb = 1'b0;
  int tot = 0, hi = 0, cut_seen = 0;
  always @(negedge clk) begin
    if (rst) begin
      started = 1'b0; prevb = 1'b0;
    end else begin
      if (cut_seq != cut_seen) begin cut_seen = cut_seq; started = 1'b0; end
      for (int s = 1; s >= 0; s--) begin
        bit b;
        b = clk_pair[s];
        if (b && !prevb) begin
          if (started && exp_tot.size() > 0) begin
            int et, eh; string tg;
            et = exp_tot.pop_front(); eh = exp_hi.pop_front(); tg = exp_tag.pop_front();
            chk(tot == et, {tg, " period length (half-slots)"}, tot, et);
            chk(hi == eh, {tg, " high time (half-slots)"}, hi, eh);
          end
          started = 1'b1; tot = 0; hi = 0;
        end
        if (started) begin tot++; if (b) hi++; end
        prevb = b;
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int hc, lat;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_pair == 2'b00, "R1 reset output", clk_pair, 0);

    // R1, R4: default divisor gives one-cycle periods, pair 10
    @(posedge clk); cut_seq++;
    push_run(1, 0, 1'b0, 4, "R4");
    wr(1'b0, cw(1'b1, 1'b0, 1'b0, 0));
    wait_empty("R1");

    run_case(4, 0, 1'b0, 3, "R2");
    run_case(5, 0, 1'b0, 3, "R3");
    run_case(5, 0, 1'b1, 3, "R3");
    run_case(3, 0, 1'b1, 3, "R3");
    run_case(6, 0, 1'b1, 2, "R3");
    run_case(3, 96, 1'b0, 8, "R2");
    run_case(4, 200, 1'b1, 6, "R2");

    // R6: change divisor right after a period starts
    run_case(4, 0, 1'b0, 2, "R6");
    push_run(4, 0, 1'b0, 1, "R6");
    wr(1'b1, (7 << 8) | 64);
    push_run(7, 64, 1'b0, 4, "R6");
    wait_empty("R6");

    // R10: each nudge edge adds one idle cycle to the current period
    run_case(5, 0, 1'b0, 2, "R10");
    for (int k = 0; k < 2; k++) begin
      exp_tot.push_back(12); exp_hi.push_back(4); exp_tag.push_back("R10");
      push_run(5, 0, 1'b0, 2, "R10");
      nud = ~nud;
      wr(1'b0, cw(1'b1, 1'b0, 1'b0, 0));
      wait_empty("R10");
    end

    // R8 / R11: clean stop mid-period, then held low
    run_case(6, 0, 1'b0, 2, "R8");
    @(negedge clk);
    hc = (clk_pair != 2'b00) ? 1 : 0;
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = cw(1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    if (clk_pair != 2'b00) hc++;
    for (int k = 0; k < 19; k++) begin
      @(negedge clk);
      if (clk_pair != 2'b00) hc++;
    end
    chk(hc == 2, "R8 high cycles after disable", hc, 2);
    chk(clk_pair == 2'b00, "R11 idle output", clk_pair, 0);

    // R7: enable delay
    for (int p = 0; p < 4; p++) begin
      wr(1'b0, cw(1'b0, 1'b1, 1'b0, 0));
      wr(1'b0, cw(1'b0, 1'b0, 1'b0, 0));
      wr(1'b0, cw(1'b1, 1'b0, 1'b0, p));
      lat = 1;
      while (clk_pair == 2'b00 && lat < 12) begin
        @(negedge clk); lat++;
      end
      chk(lat == p + 2, "R7 enable latency", lat, p + 2);
    end

    // R9: stop while enabled forces 00 at once
    repeat (3) @(negedge clk);
    wr(1'b0, cw(1'b1, 1'b1, 1'b0, 3));
    hc = 0;
    for (int k = 0; k < 8; k++) begin
      if (clk_pair != 2'b00) hc++;
      @(negedge clk);
    end
    chk(hc == 0, "R9 output while stopped", hc, 0);

    // R5: integer zero means 65536
    run_case(0, 0, 1'b0, 1, "R5");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule